// File: doc/BRIEF.md
# DMA Control Register Section

This block is the control half of a four-channel DMA controller. A byte-wide register bus reaches eight offsets, 8 through 15. Through them software can load the command byte, write a per-channel mode byte, and set, clear or load the channel mask. Software can also raise or drop a request for a channel, clear the byte-pointer flip-flop, and issue a master reset. Reads return the status byte or the mask. A status read has a side effect: it clears the terminal-count flags. The request flags are left alone.

Each channel's hardware request line is edge-tracked. A rising edge sets that channel's request flag, and a falling edge clears it. A terminal-count pulse from the neighbouring counter section sets that channel's terminal-count flag. From the mask and the request flags, a service scan produces two outputs:
- a run-enable vector, with one bit per eligible channel;
- a one-hot grant that picks the lowest-numbered eligible channel.

The byte-pointer flip-flop is kept here. The address/count section toggles it with a pulse. The mode bytes and the controller-disable command bit are exported for the neighbouring sections.

Top module: `dmac_ctl_regs`

## Requirements
- R1: After power-up reset the mask is all set (offset 15 reads 0x0F), the status reads 0x00, the command is 0 (`cmd_disable` low), `ptr_hi` is 0, every mode byte is 0, and `run_en` is 0.
- R2: A write to offset 8 loads the command only when `(wdata & 0xFB) == 0`; any other value leaves the command unchanged. `cmd_disable` is command bit 2.
- R3: A write to offset 9 selects a channel with bits 1:0. It sets that channel's request flag (status bit ch+4) when bit 2 is 1 and clears it when bit 2 is 0. In both cases it clears that channel's terminal-count flag (status bit ch).
- R4: A write to offset 10 selects a channel with bits 1:0 and sets its mask bit to data bit 2. A write to offset 14 clears all mask bits. A write to offset 15 loads the mask from data bits 3:0.
- R5: A write to offset 11 stores the full data byte as the mode of the channel in bits 1:0. It appears on `mode_flat[8*ch+7:8*ch]`.
- R6: A write to offset 12 clears `ptr_hi`, and it wins over a `ptr_flip` pulse in the same cycle. A `ptr_flip` pulse on its own inverts `ptr_hi`.
- R7: A write to offset 13 clears `ptr_hi`, the status and the command, and sets all mask bits. Mode bytes are kept.
- R8: `rdata` is valid one cycle after `rd_en` and is 0 in every other cycle. Offset 8 returns `{request[3:0], tc[3:0]}` and then clears the tc flags while keeping the request flags. Offset 15 returns `{4'b0, mask}`. Every other offset returns 0.
- R9: A rising edge on `dreq[ch]` sets request flag ch, and a falling edge clears it. A write to offset 9 or 13 in the same cycle takes precedence for the channels it touches.
- R10: A `tc_in[ch]` pulse sets terminal-count flag ch. It takes precedence over a same-cycle status-read clear, offset-9 clear or master reset.
- R11: `run_en[ch]` is 1 exactly when mask bit ch is 0 and request flag ch is 1. `grant` is one-hot on the lowest-numbered set bit of `run_en`, or 0 when `run_en` is 0.
- R12: Writes to offsets 0 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| dreq | input | 4 | Hardware request lines, one per channel |
| tc_in | input | 4 | Terminal-count pulses from the counter section |
| ptr_flip | input | 1 | Toggle pulse for the byte-pointer flip-flop |
| rdata | output | 8 | Read data, one cycle after `rd_en` |
| run_en | output | 4 | Channels eligible for service |
| grant | output | 4 | One-hot lowest-numbered eligible channel |
| ptr_hi | output | 1 | Byte-pointer flip-flop state |
| cmd_disable | output | 1 | Controller-disable command bit |
| mode_flat | output | 32 | Mode bytes, channel 0 in the low byte |

## Verification
The bench aims at the places where two updates land in the same cycle:
- A status read together with a terminal-count pulse. A design that let the read clear win would lose the flag.
- A request-clear write together with a rising `dreq`. A design that let the hardware edge win would report the channel as requesting.

Commands that carry unsupported bits are sent in two forms: a single rejected bit, and a rejected bit combined with the accepted disable bit. A design that masked the bad bits instead of dropping the whole write would change `cmd_disable`. Writes and reads at offsets 0 to 7 are chosen so that they alias to clear-mask, command and mask-read. This catches a decoder that looks only at the low three address bits. The grant is checked with several eligible channels present, which exposes a wrong priority order.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int AW  = 4;
    localparam int CSW = $clog2(NCH);

    // Only the disable bit may be set in an accepted command byte
    localparam logic [DW-1:0] CMD_KEEP = 8'h04;

    typedef enum logic [AW-1:0] {
        OFS_CMD     = 4'd8,
        OFS_SWREQ   = 4'd9,
        OFS_SMASK   = 4'd10,
        OFS_MODE    = 4'd11,
        OFS_CLRPTR  = 4'd12,
        OFS_MRESET  = 4'd13,
        OFS_CLRMASK = 4'd14,
        OFS_ALLMASK = 4'd15
    } ofs_e;

    typedef struct packed {
        logic wr_cmd;
        logic wr_swreq;
        logic wr_smask;
        logic wr_mode;
        logic wr_clrptr;
        logic wr_mreset;
        logic wr_clrmask;
        logic wr_allmask;
        logic rd_status;
        logic rd_mask;
    } strobe_t;

    typedef struct packed {
        logic [DW-1:0]          cmd;
        logic [NCH-1:0]         mask;
        logic [NCH-1:0]         req;
        logic [NCH-1:0]         tc;
        logic                   ptr_hi;
        logic [NCH-1:0][DW-1:0] mode;
        logic [NCH-1:0]         dreq_prev;
        logic [DW-1:0]          rdata;
    } ctl_state_t;
endpackage

// File: rtl/dmac_ofs_decode.sv
module dmac_ofs_decode
    import dmac_ctl_pkg::*;
(
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    output strobe_t       stb
);
    always_comb begin
        stb = '0;
        if (wr_en) begin
            case (addr)
                OFS_CMD:     stb.wr_cmd     = 1'b1;
                OFS_SWREQ:   stb.wr_swreq   = 1'b1;
                OFS_SMASK:   stb.wr_smask   = 1'b1;
                OFS_MODE:    stb.wr_mode    = 1'b1;
                OFS_CLRPTR:  stb.wr_clrptr  = 1'b1;
                OFS_MRESET:  stb.wr_mreset  = 1'b1;
                OFS_CLRMASK: stb.wr_clrmask = 1'b1;
                OFS_ALLMASK: stb.wr_allmask = 1'b1;
                default:     ;
            endcase
        end
        if (rd_en) begin
            case (addr)
                OFS_CMD:     stb.rd_status = 1'b1;
                OFS_ALLMASK: stb.rd_mask   = 1'b1;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/dmac_status_next.sv
module dmac_status_next
    import dmac_ctl_pkg::*;
(
    input  logic [NCH-1:0] req_q,
    input  logic [NCH-1:0] tc_q,
    input  logic [NCH-1:0] dreq_prev_q,
    input  logic [NCH-1:0] dreq,
    input  logic [NCH-1:0] tc_in,
    input  logic           wr_swreq,
    input  logic           wr_mreset,
    input  logic           rd_status,
    input  logic [CSW:0]   sel_bits,
    output logic [NCH-1:0] req_d,
    output logic [NCH-1:0] tc_d
);
    logic [CSW-1:0] sel;
    logic [NCH-1:0] rise, fall;

    assign sel  = sel_bits[CSW-1:0];
    assign rise = dreq & ~dreq_prev_q;
    assign fall = ~dreq & dreq_prev_q;

    always_comb begin
        // request flags: hardware edges first, bus writes override
        req_d = (req_q | rise) & ~fall;
        if (wr_swreq)  req_d[sel] = sel_bits[CSW];
        if (wr_mreset) req_d = '0;

        // terminal-count flags: clears first, new pulses win
        tc_d = tc_q;
        if (rd_status) tc_d = '0;
        if (wr_swreq)  tc_d[sel] = 1'b0;
        if (wr_mreset) tc_d = '0;
        tc_d = tc_d | tc_in;
    end
endmodule

// File: rtl/dmac_service_scan.sv
module dmac_service_scan
    import dmac_ctl_pkg::*;
(
    input  logic [NCH-1:0] mask_q,
    input  logic [NCH-1:0] req_q,
    output logic [NCH-1:0] run_en,
    output logic [NCH-1:0] grant
);
    assign run_en = req_q & ~mask_q;

    for (genvar g = 0; g < NCH; g++) begin : g_pri
        if (g == 0) begin : g_top
            assign grant[g] = run_en[g];
        end else begin : g_rest
            assign grant[g] = run_en[g] & ~(|run_en[g-1:0]);
        end
    end
endmodule

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
    import dmac_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [NCH-1:0]    dreq,
    input  logic [NCH-1:0]    tc_in,
    input  logic              ptr_flip,
    output logic [DW-1:0]     rdata,
    output logic [NCH-1:0]    run_en,
    output logic [NCH-1:0]    grant,
    output logic              ptr_hi,
    output logic              cmd_disable,
    output logic [NCH*DW-1:0] mode_flat
);
    localparam logic [DW-1:0] CMD_REJECT = ~CMD_KEEP;
    localparam int            CMD_DIS_BIT = 2;

    ctl_state_t     st_q, st_d;
    strobe_t        stb;
    logic [NCH-1:0] req_d, tc_d;
    logic [CSW-1:0] sel;

    assign sel = wdata[CSW-1:0];

    dmac_ofs_decode u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .stb   (stb)
    );

    dmac_status_next u_stat (
        .req_q       (st_q.req),
        .tc_q        (st_q.tc),
        .dreq_prev_q (st_q.dreq_prev),
        .dreq        (dreq),
        .tc_in       (tc_in),
        .wr_swreq    (stb.wr_swreq),
        .wr_mreset   (stb.wr_mreset),
        .rd_status   (stb.rd_status),
        .sel_bits    (wdata[CSW:0]),
        .req_d       (req_d),
        .tc_d        (tc_d)
    );

    dmac_service_scan u_scan (
        .mask_q (st_q.mask),
        .req_q  (st_q.req),
        .run_en (run_en),
        .grant  (grant)
    );

    always_comb begin
        st_d           = st_q;
        st_d.req       = req_d;
        st_d.tc        = tc_d;
        st_d.dreq_prev = dreq;

        if (ptr_flip) st_d.ptr_hi = ~st_q.ptr_hi;
        if (stb.wr_clrptr) st_d.ptr_hi = 1'b0;

        if (stb.wr_cmd && ((wdata & CMD_REJECT) == '0)) st_d.cmd = wdata;

        if (stb.wr_smask)   st_d.mask[sel] = wdata[CSW];
        if (stb.wr_clrmask) st_d.mask = '0;
        if (stb.wr_allmask) st_d.mask = wdata[NCH-1:0];

        if (stb.wr_mode) st_d.mode[sel] = wdata;

        if (stb.wr_mreset) begin
            st_d.ptr_hi = 1'b0;
            st_d.mask   = '1;
            st_d.cmd    = '0;
        end

        st_d.rdata = '0;
        if (stb.rd_status) st_d.rdata = {st_q.req, st_q.tc};
        if (stb.rd_mask)   st_d.rdata = {{(DW-NCH){1'b0}}, st_q.mask};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mask      <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata       = st_q.rdata;
    assign ptr_hi      = st_q.ptr_hi;
    assign cmd_disable = st_q.cmd[CMD_DIS_BIT];
    assign mode_flat   = st_q.mode;

    // R2: a command carrying unsupported bits leaves the command untouched
    a_r2_cmd_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CMD && (wdata & CMD_REJECT) != '0) |=> $stable(st_q.cmd));

    // R4: single-channel mask write lands on the selected bit
    a_r4_single_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_SMASK) |=> (st_q.mask[$past(wdata[CSW-1:0])] == $past(wdata[CSW])));

    // R7: master reset leaves everything masked, idle and with pointer low
    a_r7_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_MRESET) |=> (st_q.mask == '1 && st_q.cmd == '0 && !ptr_hi && run_en == '0));

    // R8: status read without new terminal counts leaves no tc flag set
    a_r8_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_CMD && tc_in == '0) |=> (st_q.tc == '0));

    // R10: a terminal-count pulse is never lost
    a_r10_tc_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_in != '0) |=> ((st_q.tc & $past(tc_in)) == $past(tc_in)));

    // R11: grant is a single eligible channel, present whenever any is eligible
    a_r11_grant_shape: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~run_en) == '0) && ((run_en != '0) == (grant != '0)));
endmodule

// File: tb/dmac_ctl_regs_tb_top.sv
`timescale 1ns/100ps
module dmac_ctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [3:0]  dreq = '0;
    logic [3:0]  tc_in = '0;
    logic        ptr_flip = 1'b0;
    logic [7:0]  rdata;
    logic [3:0]  run_en, grant;
    logic        ptr_hi, cmd_disable;
    logic [31:0] mode_flat;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    dmac_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .dreq(dreq), .tc_in(tc_in), .ptr_flip(ptr_flip),
        .rdata(rdata), .run_en(run_en), .grant(grant), .ptr_hi(ptr_hi),
        .cmd_disable(cmd_disable), .mode_flat(mode_flat)
    );

    // monitor: compares read data against the scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            n_chk++;
            if (rdata !== e.exp) begin
                n_fail++;
                $display("FAIL %s rdata actual=%02h expected=%02h", e.tag, rdata, e.exp);
            end
        end
    end

    task automatic drive(input logic w, input logic r, input logic [3:0] a,
                         input logic [7:0] d, input logic [3:0] dq,
                         input logic [3:0] t, input logic f,
                         input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        wr_en = w; rd_en = r; addr = a; wdata = d; dreq = dq; tc_in = t; ptr_flip = f;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0; tc_in = '0; ptr_flip = 1'b0;
        if (r) sbq.push_back('{exp, tag});
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
        drive(1'b1, 1'b0, a, d, dreq, 4'h0, 1'b0, 8'h00, "");
    endtask

    task automatic bus_rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        drive(1'b0, 1'b1, a, 8'h00, dreq, 4'h0, 1'b0, exp, tag);
    endtask

    task automatic set_dreq(input logic [3:0] dq);
        drive(1'b0, 1'b0, 4'h0, 8'h00, dq, 4'h0, 1'b0, 8'h00, "");
    endtask

    task automatic pulse_tc(input logic [3:0] t);
        drive(1'b0, 1'b0, 4'h0, 8'h00, dreq, t, 1'b0, 8'h00, "");
    endtask

    task automatic flip();
        drive(1'b0, 1'b0, 4'h0, 8'h00, dreq, 4'h0, 1'b1, 8'h00, "");
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk("R1 run_en", {28'h0, run_en}, 32'h0);
        chk("R1 ptr_hi", {31'h0, ptr_hi}, 32'h0);
        chk("R1 cmd_disable", {31'h0, cmd_disable}, 32'h0);
        chk("R1 mode_flat", mode_flat, 32'h0);
        bus_rd(4'd15, 8'h0F, "R1 mask read");
        bus_rd(4'd8,  8'h00, "R1 status read");

        // R4 mask commands
        bus_wr(4'd14, 8'h00);
        bus_rd(4'd15, 8'h00, "R4 clear all");
        bus_wr(4'd10, 8'h06);
        bus_rd(4'd15, 8'h04, "R4 single set ch2");
        bus_wr(4'd15, 8'h09);
        bus_rd(4'd15, 8'h09, "R4 load all");
        bus_wr(4'd10, 8'h00);
        bus_rd(4'd15, 8'h08, "R4 single clear ch0");

        // R2 command acceptance
        bus_wr(4'd8, 8'h04);
        chk("R2 accept disable", {31'h0, cmd_disable}, 32'h1);
        bus_wr(4'd8, 8'h01);
        chk("R2 reject bit0", {31'h0, cmd_disable}, 32'h1);
        bus_wr(4'd8, 8'h00);
        chk("R2 accept zero", {31'h0, cmd_disable}, 32'h0);
        bus_wr(4'd8, 8'h84);
        chk("R2 reject mixed", {31'h0, cmd_disable}, 32'h0);

        // R5 mode bytes
        bus_wr(4'd11, 8'h6B);
        chk("R5 mode ch3", mode_flat, 32'h6B00_0000);
        bus_wr(4'd11, 8'h91);
        chk("R5 mode ch1", mode_flat, 32'h6B00_9100);

        // R6 byte pointer
        flip();
        chk("R6 flip high", {31'h0, ptr_hi}, 32'h1);
        flip();
        chk("R6 flip low", {31'h0, ptr_hi}, 32'h0);
        flip();
        bus_wr(4'd12, 8'h00);
        chk("R6 clear", {31'h0, ptr_hi}, 32'h0);
        flip();
        drive(1'b1, 1'b0, 4'd12, 8'h00, dreq, 4'h0, 1'b1, 8'h00, "");
        chk("R6 clear beats flip", {31'h0, ptr_hi}, 32'h0);

        // R9 / R11 hardware requests, mask = 1000
        set_dreq(4'b0010);
        chk("R9 rise ch1 run_en", {28'h0, run_en}, 32'h2);
        chk("R11 grant ch1", {28'h0, grant}, 32'h2);
        set_dreq(4'b1010);
        chk("R11 masked ch3", {28'h0, run_en}, 32'h2);
        bus_rd(4'd8, 8'hA0, "R9 status req ch1 ch3");
        set_dreq(4'b1011);
        chk("R11 run_en two", {28'h0, run_en}, 32'h3);
        chk("R11 grant lowest", {28'h0, grant}, 32'h1);
        set_dreq(4'b1001);
        chk("R9 fall ch1", {28'h0, run_en}, 32'h1);

        // R8 / R10 terminal count
        pulse_tc(4'b0101);
        bus_rd(4'd8, 8'h95, "R10 tc set");
        bus_rd(4'd8, 8'h90, "R8 tc cleared by read");

        // R3 software request
        bus_wr(4'd9, 8'h06);
        bus_rd(4'd8, 8'hD0, "R3 set req ch2");
        chk("R11 grant with ch2", {28'h0, grant}, 32'h1);
        pulse_tc(4'b0100);
        bus_wr(4'd9, 8'h02);
        bus_rd(4'd8, 8'h90, "R3 clear req and tc ch2");

        // R10 pulse during status read survives
        drive(1'b0, 1'b1, 4'd8, 8'h00, dreq, 4'b0010, 1'b0, 8'h90, "R10 read same cycle");
        bus_rd(4'd8, 8'h92, "R10 tc kept over read");
        bus_rd(4'd8, 8'h90, "R8 second read clears");

        // R9 bus write wins over same-cycle edge
        drive(1'b1, 1'b0, 4'd9, 8'h02, 4'b1101, 4'h0, 1'b0, 8'h00, "");
        bus_rd(4'd8, 8'h90, "R9 write beats edge");
        bus_wr(4'd10, 8'h04);
        chk("R11 all masked run_en", {28'h0, run_en}, 32'h0);
        chk("R11 all masked grant", {28'h0, grant}, 32'h0);

        // R7 master reset
        bus_wr(4'd8, 8'h04);
        flip();
        bus_wr(4'd13, 8'h00);
        chk("R7 cmd cleared", {31'h0, cmd_disable}, 32'h0);
        chk("R7 ptr cleared", {31'h0, ptr_hi}, 32'h0);
        chk("R7 modes kept", mode_flat, 32'h6B00_9100);
        bus_rd(4'd15, 8'h0F, "R7 mask set");
        bus_rd(4'd8,  8'h00, "R7 status cleared");

        // R12 low offsets ignored, R8 other reads zero
        bus_wr(4'd6, 8'h00);
        bus_rd(4'd15, 8'h0F, "R12 offset 6 ignored");
        bus_wr(4'd0, 8'h04);
        chk("R12 offset 0 ignored", {31'h0, cmd_disable}, 32'h0);
        bus_wr(4'd3, 8'h2F);
        chk("R12 offset 3 ignored", mode_flat, 32'h6B00_9100);
        bus_rd(4'd7, 8'h00, "R8 offset 7 reads zero");
        bus_rd(4'd9, 8'h00, "R8 offset 9 reads zero");
        @(posedge clk); #1;
        chk("R8 idle rdata zero", {24'h0, rdata}, 32'h0);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule